// File: doc/BRIEF.md
# Single-Channel Host-Memory DMA Write Engine

This block moves a block of 32-bit words from a local data stream into host memory on its own, without the host copying the data. Software programs two values through single-word register writes: the host destination address, then the byte count. The write of the byte count also starts the job; the block has no separate start bit. The engine cuts the job into memory-write requests toward a bus endpoint back end. Each request has one header beat followed by its payload beats. When the last payload beat has been taken, the engine raises an interrupt. The interrupt stays high until software writes zero to an acknowledge register.

Addresses and lengths count whole words, so the two low bits of each are dropped. A request carries at most 128 bytes and never runs past a 4 KB address boundary. The engine does no arbitration. It presents each beat and waits until the back end takes it.

Both data interfaces use valid/ready. A beat moves on a clock edge where both valid and ready are high. `out_valid` and the beat contents stay fixed while `out_ready` is low. During payload the stream input passes straight through. `in_ready` follows `out_ready`, and `out_valid` follows `in_valid`. The local source must therefore hold `in_valid` and `in_data` until the word is taken.

Top module: `dma_wr_engine`

## Requirements
- R1: A write to register index 0 (address register) while idle stores the host address with its two low bits cleared, and reading index 0 returns that value.
- R2: A write to register index 1 (length register) while idle stores the byte count with its two low bits cleared. If that count is nonzero, the same write starts a transfer, and the busy bit is set from the next cycle.
- R3: Every request announces a payload of 4 to 128 bytes in steps of 4, and it is followed by exactly that many bytes divided by four payload beats.
- R4: No request crosses a 4 KB address boundary. A piece that would cross one is cut to end exactly at the boundary.
- R5: Each request starts where the previous one ended. The last request carries whatever bytes remain, and the payloads add up to the programmed count.
- R6: A header beat has `out_sop`=1 and `out_data` equal to the request address, and `out_bytes` gives the payload size. Payload beats have `out_sop`=0, and `out_last`=1 only on the final beat of the request.
- R7: A stream word is consumed only when `in_valid` and `in_ready` are both high. `in_ready` is high only during payload while `out_ready` is high. During payload, `out_valid` and `out_data` follow `in_valid` and `in_data`.
- R8: `irq` goes high in the cycle after the final payload beat of the transfer is accepted, and never earlier.
- R9: `irq` stays high until software writes the value zero to register index 2. A nonzero write there leaves it set.
- R10: A length that becomes zero once its low bits are cleared starts nothing. No beat is issued and no interrupt is raised.
- R11: Writes to the address or length register while busy change neither the readback nor the running transfer.
- R12: Register index 3 reads status: bit 0 busy, bit 1 done, bit 2 interrupt pending. Done is set at completion and cleared by the next start.
- R13: After reset no beat is offered, `irq` is low, and registers 0, 1 and 3 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| in_valid | input | 1 | Local stream word valid |
| in_ready | output | 1 | Local stream word taken when high with `in_valid` |
| in_data | input | DW | Local stream word |
| out_valid | output | 1 | Request beat valid |
| out_ready | input | 1 | Back end accepts the beat |
| out_sop | output | 1 | Beat is a request header |
| out_last | output | 1 | Final payload beat of a request |
| out_data | output | DW | Header: address; payload: data word |
| out_bytes | output | log2(MAX_BYTES)+1 | Payload byte count of the current request |
| irq | output | 1 | Completion interrupt, held until acknowledged |

## Verification
If the remaining-count or address counters go wrong, the fault shows at the very next header beat. That header carries a wrong address or a wrong size, or the transfer ends too early or too late. The `irq` rise then moves by whole requests. If the per-request beat counter goes wrong, `out_last` lands on the wrong beat within the same request, and stream words are consumed in the wrong number. If the register file is wrong, a status read or a readback made right after the write exposes it, and so does a transfer started at the wrong address or not started at all.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  // Register indices seen on reg_addr
  typedef enum logic [1:0] {
    REG_DEST = 2'd0,
    REG_LEN  = 2'd1,
    REG_ACK  = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  // Transfer sequencer phases
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_HDR  = 2'd1,
    XS_PAY  = 2'd2
  } xstate_e;
endpackage

// File: rtl/dmaw_regs.sv
module dmaw_regs
  import dmaw_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          busy,
  input  logic          fin,
  output logic          start,
  output logic [AW-1:0] start_addr,
  output logic [LW-1:0] start_len,
  output logic          irq
);
  logic [AW-1:0] dest_q;
  logic [LW-1:0] len_q;
  logic          done_q;
  logic          irq_q;
  logic [LW-1:0] wr_len;
  logic          wr_dest, wr_len_en, ack_zero;

  assign wr_len    = {reg_wdata[LW-1:2], 2'b00};
  assign wr_dest   = reg_wr && (reg_addr == REG_DEST) && !busy;
  assign wr_len_en = reg_wr && (reg_addr == REG_LEN) && !busy;
  assign ack_zero  = reg_wr && (reg_addr == REG_ACK) && (reg_wdata == 32'd0);
  assign start      = wr_len_en && (wr_len != '0);
  assign start_addr = dest_q;
  assign start_len  = wr_len;
  assign irq        = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0;
      len_q  <= '0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_dest)   dest_q <= {reg_wdata[AW-1:2], 2'b00};
      if (wr_len_en) len_q  <= wr_len;
      if (fin)        done_q <= 1'b1;
      else if (start) done_q <= 1'b0;
      // completion wins over a same-cycle acknowledge
      if (fin)           irq_q <= 1'b1;
      else if (ack_zero) irq_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr)
      REG_DEST: reg_rdata = 32'(dest_q);
      REG_LEN:  reg_rdata = 32'(len_q);
      REG_ACK:  reg_rdata = {31'd0, irq_q};
      default:  reg_rdata = {29'd0, irq_q, done_q, busy};
    endcase
  end
endmodule

// File: rtl/dmaw_split.sv
module dmaw_split #(
  parameter int LW        = 16,
  parameter int MAX_BYTES = 128,
  parameter int BOUNDARY  = 4096,
  localparam int BW = $clog2(BOUNDARY),
  localparam int CW = $clog2(MAX_BYTES) + 1
) (
  input  logic [BW-1:0] addr_low,
  input  logic [LW-1:0] rem,
  output logic [CW-1:0] chunk
);
  logic [31:0] to_bnd;
  logic [31:0] lim;

  // size = min(remaining, max payload, bytes up to the next boundary)
  always_comb begin
    to_bnd = 32'(BOUNDARY) - 32'(addr_low);
    lim    = 32'(MAX_BYTES);
    if (to_bnd < lim) lim = to_bnd;
    if (32'(rem) < lim) lim = 32'(rem);
    chunk = CW'(lim);
  end
endmodule

// File: rtl/dmaw_xfer.sv
module dmaw_xfer
  import dmaw_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] start_len,
  input  logic [CW-1:0] chunk,
  output logic [AW-1:0] cur_addr,
  output logic [LW-1:0] cur_rem,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_sop,
  output logic          out_last,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] out_bytes,
  output logic          busy,
  output logic          fin
);
  xstate_e       state;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q;
  logic [CW-1:0] req_bytes;
  logic [CW-1:0] left_q;
  logic          in_hdr, in_pay, pay_fire, last_beat, job_end;

  assign in_hdr    = (state == XS_HDR);
  assign in_pay    = (state == XS_PAY);
  assign pay_fire  = in_pay && out_ready && in_valid;
  assign last_beat = (left_q == CW'(4));
  assign job_end   = (rem_q == LW'(req_bytes));
  assign fin       = pay_fire && last_beat && job_end;
  assign busy      = (state != XS_IDLE);
  assign cur_addr  = addr_q;
  assign cur_rem   = rem_q;

  assign out_valid = in_hdr || (in_pay && in_valid);
  assign out_sop   = in_hdr;
  assign out_last  = in_pay && last_beat;
  assign out_data  = in_hdr ? DW'(addr_q) : in_data;
  assign out_bytes = in_hdr ? chunk : req_bytes;
  assign in_ready  = in_pay && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= XS_IDLE;
      addr_q    <= '0;
      rem_q     <= '0;
      req_bytes <= '0;
      left_q    <= '0;
    end else begin
      unique case (state)
        XS_IDLE: if (start) begin
          addr_q <= start_addr;
          rem_q  <= start_len;
          state  <= XS_HDR;
        end
        XS_HDR: if (out_ready) begin
          req_bytes <= chunk;
          left_q    <= chunk;
          state     <= XS_PAY;
        end
        XS_PAY: if (pay_fire) begin
          left_q <= left_q - CW'(4);
          if (last_beat) begin
            addr_q <= addr_q + AW'(req_bytes);
            rem_q  <= rem_q - LW'(req_bytes);
            state  <= job_end ? XS_IDLE : XS_HDR;
          end
        end
        default: state <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_wr_engine.sv
module dma_wr_engine #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LW        = 16,
  parameter int MAX_BYTES = 128,
  parameter int BOUNDARY  = 4096
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [1:0]                 reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DW-1:0]              in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic                       out_sop,
  output logic                       out_last,
  output logic [DW-1:0]              out_data,
  output logic [$clog2(MAX_BYTES):0] out_bytes,
  output logic                       irq
);
  localparam int CW = $clog2(MAX_BYTES) + 1;
  localparam int BW = $clog2(BOUNDARY);

  logic          busy, fin, start;
  logic [AW-1:0] start_addr, cur_addr;
  logic [LW-1:0] start_len, cur_rem;
  logic [CW-1:0] chunk;

  dmaw_regs #(.AW(AW), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .fin(fin),
    .start(start), .start_addr(start_addr), .start_len(start_len), .irq(irq)
  );

  dmaw_split #(.LW(LW), .MAX_BYTES(MAX_BYTES), .BOUNDARY(BOUNDARY)) u_split (
    .addr_low(cur_addr[BW-1:0]), .rem(cur_rem), .chunk(chunk)
  );

  dmaw_xfer #(.AW(AW), .DW(DW), .LW(LW), .CW(CW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_len(start_len), .chunk(chunk), .cur_addr(cur_addr), .cur_rem(cur_rem),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
    .out_last(out_last), .out_data(out_data), .out_bytes(out_bytes),
    .busy(busy), .fin(fin)
  );
endmodule

// File: rtl/dmaw_chk.sv
module dmaw_chk #(
  parameter int DW        = 32,
  parameter int MAX_BYTES = 128,
  parameter int BOUNDARY  = 4096,
  localparam int CW = $clog2(MAX_BYTES) + 1,
  localparam int BW = $clog2(BOUNDARY)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_sop,
  input logic          out_last,
  input logic [DW-1:0] out_data,
  input logic [CW-1:0] out_bytes,
  input logic          irq,
  input logic          busy
);
  a_r3_max_len: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |->
      (out_bytes != '0) && (32'(out_bytes) <= MAX_BYTES) && (out_bytes[1:0] == 2'b00));

  a_r4_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> (32'(out_data[BW-1:0]) + 32'(out_bytes) <= BOUNDARY));

  a_r6_hdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop && !out_ready) |=>
      (out_valid && out_sop && $stable(out_data) && $stable(out_bytes)));

  a_r7_ready_in_job: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && out_ready && !out_sop));

  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(out_valid && out_ready && out_last));

  a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_wr && reg_addr == 2'd2 && reg_wdata == 32'd0)) |=> irq);
endmodule

bind dma_wr_engine dmaw_chk #(.DW(DW), .MAX_BYTES(MAX_BYTES), .BOUNDARY(BOUNDARY)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_sop(out_sop), .out_last(out_last),
  .out_data(out_data), .out_bytes(out_bytes), .irq(irq), .busy(busy)
);

// File: tb/tb_dma_wr_engine.sv
module tb_dma_wr_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = 32'd0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_sop, out_last;
  logic [31:0] out_data;
  logic [7:0]  out_bytes;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int src_cnt = 0;

  always #10 clk = ~clk;

  dma_wr_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_sop(out_sop), .out_last(out_last),
    .out_data(out_data), .out_bytes(out_bytes), .irq(irq)
  );

  function automatic logic [31:0] pat(int n);
    return 32'hC0DE_0000 + 32'(n);
  endfunction

  function automatic int exp_chunk(logic [31:0] a, int r);
    int m = 128;
    int b = 4096 - int'(a[11:0]);
    if (b < m) m = b;
    if (r < m) m = r;
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] val);
    reg_wr = 1'b1; reg_addr = sel; reg_wdata = val;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [31:0] val);
    reg_addr = sel;
    #5 val = reg_rdata;
    @(negedge clk);
  endtask

  task automatic run_xfer(input logic [31:0] dest, input int len, input int rp, input int vp, input bit inj);
    logic [31:0] ea, v;
    int er, left, chunk, cyc;
    bit hdr_next, fin, early, frame_ok;
    ea = dest & 32'hFFFF_FFFC;
    er = len & 32'h0000_FFFC;
    hdr_next = 1; fin = 0; early = 0; frame_ok = 1; left = 0; chunk = 0; cyc = 0;
    wr_reg(2'd0, dest);
    wr_reg(2'd1, 32'(len));
    rd_reg(2'd3, v);
    chk(v[2:0] == 3'b001, "R2/R12 status busy after start", v, 32'd1);
    while (!fin && cyc < 20000) begin
      out_ready = ($urandom_range(99) < rp);
      in_valid  = ($urandom_range(99) < vp);
      in_data   = pat(src_cnt);
      reg_wr    = inj && (cyc == 3 || cyc == 4);
      reg_addr  = (cyc == 3) ? 2'd0 : 2'd1;
      reg_wdata = (cyc == 3) ? 32'h0000_0800 : 32'h0000_0040;
      #5;
      if (irq) early = 1;
      if (!hdr_next && !in_valid && out_valid) frame_ok = 0;
      if (out_valid && out_ready) begin
        if (hdr_next) begin
          chunk = exp_chunk(ea, er);
          chk(out_sop == 1'b1, "R6 header beat flagged", 32'(out_sop), 32'd1);
          chk(out_data == ea, "R5 request address", out_data, ea);
          chk(int'(out_bytes) == chunk, "R3/R4 request size", 32'(out_bytes), 32'(chunk));
          left = chunk / 4;
          hdr_next = 0;
        end else begin
          chk(!out_sop && out_data == pat(src_cnt) && in_ready,
              "R7 payload pass-through", out_data, pat(src_cnt));
          chk(out_last == (left == 1), "R6 last flag", 32'(out_last), 32'(left == 1));
          src_cnt++;
          left--;
          if (left == 0) begin
            ea = ea + 32'(chunk);
            er = er - chunk;
            hdr_next = 1;
            if (er == 0) fin = 1;
          end
        end
      end
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
      cyc++;
    end
    out_ready = 1'b0; in_valid = 1'b0;
    chk(fin, "R5 all bytes sent", 32'(fin), 32'd1);
    chk(!early, "R8 no early irq", 32'(early), 32'd0);
    chk(frame_ok, "R7 payload valid follows in_valid", 32'(frame_ok), 32'd1);
    reg_addr = 2'd3;
    #5;
    chk(irq == 1'b1, "R8 irq after last beat", 32'(irq), 32'd1);
    chk(reg_rdata[2:0] == 3'b110, "R12 status done+irq", reg_rdata, 32'd6);
    @(negedge clk);
    if (inj) begin
      rd_reg(2'd0, v);
      chk(v == (dest & 32'hFFFF_FFFC), "R11 address write while busy ignored", v, dest & 32'hFFFF_FFFC);
      rd_reg(2'd1, v);
      chk(v == 32'(len & 32'h0000_FFFC), "R11 length write while busy ignored", v, 32'(len & 32'h0000_FFFC));
    end
    wr_reg(2'd2, 32'h0000_0001);
    chk(irq == 1'b1, "R9 nonzero ack keeps irq", 32'(irq), 32'd1);
    wr_reg(2'd2, 32'd0);
    chk(irq == 1'b0, "R9 zero ack clears irq", 32'(irq), 32'd0);
    rd_reg(2'd3, v);
    chk(v[2:0] == 3'b010, "R12 status done only", v, 32'd2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R8 watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(!out_valid && !irq, "R13 idle outputs after reset", {30'd0, out_valid, irq}, 32'd0);
    rd_reg(2'd0, v); chk(v == 32'd0, "R13 address reg reset", v, 32'd0);
    rd_reg(2'd1, v); chk(v == 32'd0, "R13 length reg reset", v, 32'd0);
    rd_reg(2'd3, v); chk(v == 32'd0, "R13 status reset", v, 32'd0);

    // R1 address readback, low bits dropped
    wr_reg(2'd0, 32'h1234_5677);
    rd_reg(2'd0, v); chk(v == 32'h1234_5674, "R1 address readback", v, 32'h1234_5674);

    // R10 zero length (low bits only) starts nothing
    wr_reg(2'd1, 32'h0000_0003);
    out_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      #5 if (out_valid || irq) chk(0, "R10 zero length issued activity", 32'(out_valid), 32'd0);
      @(negedge clk);
    end
    out_ready = 1'b0;
    rd_reg(2'd3, v); chk(v[2:0] == 3'b000, "R10 status stays idle", v, 32'd0);

    // directed corner cases
    run_xfer(32'h0000_0FC0, 256, 100, 100, 0);  // R4 cut at boundary, then 128, then 64
    run_xfer(32'h0001_1000, 128, 70, 80, 1);    // exact single piece, busy writes (R11)
    run_xfer(32'h0002_0FFC, 4, 50, 50, 0);      // single word at boundary edge
    run_xfer(32'h0003_0103, 32'h10A, 60, 90, 0);// low bits dropped (R2)
    rd_reg(2'd1, v); chk(v == 32'h108, "R2 length readback", v, 32'h108);

    // constrained random transfers
    for (int t = 0; t < 10; t++) begin
      run_xfer($urandom, int'($urandom_range(1, 300)) * 4,
               int'($urandom_range(40, 100)), int'($urandom_range(40, 100)), t == 5);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule